// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits between a 16-bit word-addressed CPU bus and four slave devices. During each requested cycle it works out which slave owns the address, raises that slave's strobe, and passes on a local offset: the bus address minus the base of the slave's window. Read data comes back one cycle later, from whichever slave was strobed in the previous cycle. This suits slaves that register their read data.

The address map is fixed and sparse, and every window has its own access rights:

| Window | Range | Access |
|---|---|---|
| Program ROM | 0x0000–0x3FFF | read only |
| Console | single word at 0x4000 | write only |
| Framebuffer peripheral | 0x4100–0x4103, four registers | read and write |
| Data RAM | 0x8000–0xFFFF | read and write |

Some requests are faults: an address in no window, a write to the ROM, and a read from the console. A fault raises no strobe. In the following cycle it produces an error pulse with zero read data, and it sets a sticky error flag that only reset clears.

The response side is a small state machine with the states `RSP_IDLE`, `RSP_ROM`, `RSP_FB`, `RSP_RAM` and `RSP_ERR`. It takes its next state from every cycle's request:
- A faulting request moves it to `RSP_ERR`.
- A permitted read moves it to the state of the slave that was read.
- A permitted write, or no request, moves it to `RSP_IDLE`.

From any state, all of these transitions are possible. Reset enters `RSP_IDLE`.

Top module: `bus_addr_decoder`

## Requirements
- R1: A request in 0x0000–0x3FFF raises `rom_sel`, with `slv_off` equal to the address.
- R2: A request in 0x8000–0xFFFF raises `ram_sel`, with `slv_off` equal to the address minus 0x8000, for both reads and writes.
- R3: A request in 0x4100–0x4103 raises `fb_sel`, with `slv_off` 0 to 3, for both reads and writes.
- R4: A write to 0x4000 raises `con_sel` with `slv_we` high and the write data on `slv_wdata`.
- R5: A request to an address outside all four windows (for example 0x4001, 0x40FF, 0x4104, 0x7FFF) raises no strobe. The following cycle shows `bus_err` high and `bus_rdata` 0x0000.
- R6: A write to the ROM window is a fault: no strobe, and the error response of R5.
- R7: A read from 0x4000 is a fault: no strobe, and the error response of R5.
- R8: The cycle after a permitted read, `bus_rdata` equals the read data of the slave that was read. In a cycle after a write or after no request, `bus_rdata` is 0x0000.
- R9: `bus_err` is high only in the cycle directly after a faulting request.
- R10: `err_sticky` rises together with the first `bus_err` and stays high until reset.
- R11: After reset, `bus_err`, `err_sticky` and `bus_rdata` are all zero.
- R12: At most one slave strobe is high in any cycle, and none is high without `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| bus_err | output | 1 | Fault pulse, one cycle after the request |
| err_sticky | output | 1 | Fault seen since reset |
| slv_we | output | 1 | Write qualifier shared by all slaves |
| slv_wdata | output | 16 | Write data shared by all slaves |
| slv_off | output | 16 | Offset of the address inside the selected window |
| rom_sel | output | 1 | ROM strobe |
| rom_rdata | input | 16 | ROM read data |
| con_sel | output | 1 | Console strobe |
| fb_sel | output | 1 | Framebuffer strobe |
| fb_rdata | input | 16 | Framebuffer read data |
| ram_sel | output | 1 | RAM strobe |
| ram_rdata | input | 16 | RAM read data |

## Verification
The assertions check, on every cycle:
- the strobes are one-hot or all off, and quiet without a request;
- the ROM is never strobed for a write and the console never for a read;
- every error pulse follows a request that raised no strobe, and carries zero data;
- the sticky flag covers every pulse and never falls;
- read data tracks the slave that was read one cycle earlier.

Only the directed scenarios show the following:
- the exact window edges and offsets;
- the classification of particular unmapped addresses;
- that a faulting write leaves the framebuffer registers and the console untouched;
- that the error pulse ends after one cycle when an idle or legal cycle follows.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int NUM_RGN = 4;

    // Window indices: 0 ROM, 1 console, 2 framebuffer, 3 RAM
    localparam int RGN_BASE  [NUM_RGN] = '{32'h0000, 32'h4000, 32'h4100, 32'h8000};
    localparam int RGN_WORDS [NUM_RGN] = '{16384, 1, 4, 32768};
    localparam bit RGN_RD    [NUM_RGN] = '{1'b1, 1'b0, 1'b1, 1'b1};
    localparam bit RGN_WR    [NUM_RGN] = '{1'b0, 1'b1, 1'b1, 1'b1};

    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_ROM  = 3'd1,
        RGN_CON  = 3'd2,
        RGN_FB   = 3'd3,
        RGN_RAM  = 3'd4
    } rgn_e;

    typedef enum logic [2:0] {
        RSP_IDLE,
        RSP_ROM,
        RSP_FB,
        RSP_RAM,
        RSP_ERR
    } rsp_e;

endpackage

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
    import bmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [ADDR_W-1:0] offset
);

    logic [NUM_RGN-1:0] hit;
    logic [ADDR_W-1:0]  base;

    // One range comparator per window
    for (genvar i = 0; i < NUM_RGN; i++) begin : g_win
        assign hit[i] = (32'(addr) >= RGN_BASE[i]) &&
                        (32'(addr) <  (RGN_BASE[i] + RGN_WORDS[i]));
    end

    // Windows do not overlap, so at most one hit is set
    always_comb begin
        rgn  = RGN_NONE;
        base = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (hit[i]) begin
                rgn  = rgn_e'(i + 1);
                base = ADDR_W'(RGN_BASE[i]);
            end
        end
    end

    assign offset = addr - base;

endmodule

// File: rtl/bmd_access_check.sv
module bmd_access_check
    import bmd_pkg::*;
(
    input  logic req,
    input  logic we,
    input  rgn_e rgn,
    output logic grant,
    output logic fault
);

    logic allowed;

    // An access with no hit, or one that lacks the right, is refused
    always_comb begin
        allowed = 1'b0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (rgn == rgn_e'(i + 1)) begin
                allowed = we ? RGN_WR[i] : RGN_RD[i];
            end
        end
    end

    assign grant = req &  allowed;
    assign fault = req & ~allowed;

endmodule

// File: rtl/bmd_resp_fsm.sv
module bmd_resp_fsm
    import bmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              fault,
    input  logic              we,
    input  rgn_e              rgn,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] fb_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              sticky
);

    rsp_e state, state_nx;

    // Next-state selection from the current request
    always_comb begin
        state_nx = RSP_IDLE;
        if (fault) begin
            state_nx = RSP_ERR;
        end else if (grant && !we) begin
            unique case (rgn)
                RGN_ROM: state_nx = RSP_ROM;
                RGN_FB:  state_nx = RSP_FB;
                RGN_RAM: state_nx = RSP_RAM;
                default: state_nx = RSP_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= state_nx;
    end

    // Sticky fault flag
    always_ff @(posedge clk) begin
        if (!rst_n)     sticky <= 1'b0;
        else if (fault) sticky <= 1'b1;
    end

    // Outputs decoded from the state
    always_comb begin
        rdata = '0;
        err   = 1'b0;
        unique case (state)
            RSP_IDLE: rdata = '0;
            RSP_ROM:  rdata = rom_rdata;
            RSP_FB:   rdata = fb_rdata;
            RSP_RAM:  rdata = ram_rdata;
            RSP_ERR:  err   = 1'b1;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
    import bmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              err_sticky,
    output logic              slv_we,
    output logic [DATA_W-1:0] slv_wdata,
    output logic [ADDR_W-1:0] slv_off,
    output logic              rom_sel,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic              con_sel,
    output logic              fb_sel,
    input  logic [DATA_W-1:0] fb_rdata,
    output logic              ram_sel,
    input  logic [DATA_W-1:0] ram_rdata
);

    rgn_e               rgn;
    logic               grant;
    logic               fault;
    logic [NUM_RGN-1:0] sel;

    bmd_region_decode u_dec (
        .addr   (bus_addr),
        .rgn    (rgn),
        .offset (slv_off)
    );

    bmd_access_check u_acc (
        .req   (bus_req),
        .we    (bus_we),
        .rgn   (rgn),
        .grant (grant),
        .fault (fault)
    );

    // One strobe per window, raised only for a granted access
    for (genvar i = 0; i < NUM_RGN; i++) begin : g_sel
        assign sel[i] = grant && (rgn == rgn_e'(i + 1));
    end

    assign rom_sel   = sel[0];
    assign con_sel   = sel[1];
    assign fb_sel    = sel[2];
    assign ram_sel   = sel[3];
    assign slv_we    = grant & bus_we;
    assign slv_wdata = bus_wdata;

    bmd_resp_fsm u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (grant),
        .fault     (fault),
        .we        (bus_we),
        .rgn       (rgn),
        .rom_rdata (rom_rdata),
        .fb_rdata  (fb_rdata),
        .ram_rdata (ram_rdata),
        .rdata     (bus_rdata),
        .err       (bus_err),
        .sticky    (err_sticky)
    );

endmodule

// File: rtl/bmd_checker.sv
module bmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic [15:0] bus_rdata,
    input logic        bus_err,
    input logic        err_sticky,
    input logic        slv_we,
    input logic        rom_sel,
    input logic [15:0] rom_rdata,
    input logic        con_sel,
    input logic        fb_sel,
    input logic [15:0] fb_rdata,
    input logic        ram_sel,
    input logic [15:0] ram_rdata
);

    logic any_sel;
    assign any_sel = rom_sel | con_sel | fb_sel | ram_sel;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, con_sel, fb_sel, ram_sel})); // R12
    AST_NO_REQ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> !any_sel); // R12
    AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> !slv_we); // R6
    AST_CON_NEVER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        con_sel |-> slv_we); // R7
    AST_ERR_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req && !any_sel)); // R9
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == 16'h0000)); // R5
    AST_STICKY_COVERS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> err_sticky); // R10
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R10
    AST_ROM_DATA_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rom_sel && !slv_we) |-> (bus_rdata == rom_rdata)); // R8
    AST_FB_DATA_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fb_sel && !slv_we) |-> (bus_rdata == fb_rdata)); // R8
    AST_RAM_DATA_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ram_sel && !slv_we) |-> (bus_rdata == ram_rdata)); // R8

endmodule

bind bus_addr_decoder bmd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_rdata  (bus_rdata),
    .bus_err    (bus_err),
    .err_sticky (err_sticky),
    .slv_we     (slv_we),
    .rom_sel    (rom_sel),
    .rom_rdata  (rom_rdata),
    .con_sel    (con_sel),
    .fb_sel     (fb_sel),
    .fb_rdata   (fb_rdata),
    .ram_sel    (ram_sel),
    .ram_rdata  (ram_rdata)
);

// File: tb/sim_bus_addr_decoder.sv
`timescale 1ns/1ps
module sim_bus_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err, err_sticky, slv_we;
    logic [15:0] slv_wdata, slv_off;
    logic        rom_sel, con_sel, fb_sel, ram_sel;
    logic [15:0] rom_rdata, fb_rdata, ram_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bus_addr_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .err_sticky(err_sticky), .slv_we(slv_we),
        .slv_wdata(slv_wdata), .slv_off(slv_off), .rom_sel(rom_sel),
        .rom_rdata(rom_rdata), .con_sel(con_sel), .fb_sel(fb_sel),
        .fb_rdata(fb_rdata), .ram_sel(ram_sel), .ram_rdata(ram_rdata)
    );

    // Slave stubs with one cycle of read latency
    logic [15:0] fb_regs [4];
    logic [15:0] con_last = '0;
    int          con_cnt  = 0;

    always_ff @(posedge clk) begin
        if (rom_sel && !slv_we) rom_rdata <= {2'b10, slv_off[13:0]};
        if (ram_sel && !slv_we) ram_rdata <= {1'b0, slv_off[14:0]} ^ 16'h5A5A;
        if (fb_sel && !slv_we)  fb_rdata  <= fb_regs[slv_off[1:0]];
        if (fb_sel && slv_we)   fb_regs[slv_off[1:0]] <= slv_wdata;
        if (con_sel && slv_we) begin
            con_last <= slv_wdata;
            con_cnt  <= con_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access; strobe vector order is {ram, fb, con, rom}
    task automatic access(input string req, input logic we, input logic [15:0] a,
                          input logic [15:0] wd, input logic [3:0] exp_sel,
                          input logic [15:0] exp_off, input logic [15:0] exp_rd,
                          input logic exp_err);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        #1;
        chk({req, " strobe"}, {28'd0, ram_sel, fb_sel, con_sel, rom_sel}, {28'd0, exp_sel});
        if (exp_sel != 4'b0000) chk({req, " offset"}, {16'd0, slv_off}, {16'd0, exp_off});
        if (exp_sel != 4'b0000) chk({req, " we"}, {31'd0, slv_we}, {31'd0, we});
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk({req, " err"}, {31'd0, bus_err}, {31'd0, exp_err});
        if (!we || exp_err) chk({req, " rdata"}, {16'd0, bus_rdata}, {16'd0, exp_rd});
    endtask

    task automatic t_reset;
        chk("R11 err", {31'd0, bus_err}, 32'd0);
        chk("R11 sticky", {31'd0, err_sticky}, 32'd0);
        chk("R11 rdata", {16'd0, bus_rdata}, 32'd0);
    endtask

    task automatic t_rom;
        access("R1 rom low", 1'b0, 16'h0000, 16'h0, 4'b0001, 16'h0000, 16'h8000, 1'b0);
        access("R1 rom mid", 1'b0, 16'h1234, 16'h0, 4'b0001, 16'h1234, 16'h9234, 1'b0);
        access("R1 rom top", 1'b0, 16'h3FFF, 16'h0, 4'b0001, 16'h3FFF, 16'hBFFF, 1'b0);
    endtask

    task automatic t_ram;
        access("R2 ram base", 1'b0, 16'h8000, 16'h0, 4'b1000, 16'h0000, 16'h5A5A, 1'b0);
        access("R2 ram top", 1'b0, 16'hFFFF, 16'h0, 4'b1000, 16'h7FFF, 16'h25A5, 1'b0);
        access("R2 ram write", 1'b1, 16'h8010, 16'hBEEF, 4'b1000, 16'h0010, 16'h0, 1'b0);
        chk("R8 rdata after write", {16'd0, bus_rdata}, 32'd0);
    endtask

    task automatic t_fb;
        for (int i = 0; i < 4; i++)
            access("R3 fb write", 1'b1, 16'h4100 + 16'(i), 16'hC0D0 + 16'(i), 4'b0100,
                   16'(i), 16'h0, 1'b0);
        for (int i = 3; i >= 0; i--)
            access("R3 fb read", 1'b0, 16'h4100 + 16'(i), 16'h0, 4'b0100,
                   16'(i), 16'hC0D0 + 16'(i), 1'b0);
    endtask

    task automatic t_con;
        access("R4 console write", 1'b1, 16'h4000, 16'h0041, 4'b0010, 16'h0000, 16'h0, 1'b0);
        chk("R4 console data", {16'd0, con_last}, 32'h41);
        chk("R4 console count", con_cnt, 32'd1);
        chk("R10 sticky clear before fault", {31'd0, err_sticky}, 32'd0);
    endtask

    task automatic t_unmapped;
        access("R5 0x4001", 1'b0, 16'h4001, 16'h0, 4'b0000, 16'h0, 16'h0, 1'b1);
        chk("R10 sticky set", {31'd0, err_sticky}, 32'd1);
        access("R5 0x40FF", 1'b0, 16'h40FF, 16'h0, 4'b0000, 16'h0, 16'h0, 1'b1);
        access("R5 0x4104", 1'b1, 16'h4104, 16'hDEAD, 4'b0000, 16'h0, 16'h0, 1'b1);
        access("R5 0x7FFF", 1'b0, 16'h7FFF, 16'h0, 4'b0000, 16'h0, 16'h0, 1'b1);
        access("R5 fb untouched", 1'b0, 16'h4103, 16'h0, 4'b0100, 16'h3, 16'hC0D3, 1'b0);
    endtask

    task automatic t_rights;
        access("R6 rom write", 1'b1, 16'h0010, 16'h1111, 4'b0000, 16'h0, 16'h0, 1'b1);
        access("R7 console read", 1'b0, 16'h4000, 16'h0, 4'b0000, 16'h0, 16'h0, 1'b1);
        chk("R7 console count unchanged", con_cnt, 32'd1);
    endtask

    task automatic t_pulse;
        // Fault then a legal read in the very next cycle
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 16'h5000;
        @(negedge clk);
        bus_addr = 16'h0007;
        chk("R9 err on fault", {31'd0, bus_err}, 32'd1);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R9 err ends", {31'd0, bus_err}, 32'd0);
        chk("R8 data after fault", {16'd0, bus_rdata}, 32'h8007);
        @(negedge clk);
        chk("R8 idle rdata", {16'd0, bus_rdata}, 32'd0);
        chk("R9 idle err", {31'd0, bus_err}, 32'd0);
        chk("R10 sticky holds", {31'd0, err_sticky}, 32'd1);
    endtask

    task automatic t_rereset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 sticky after reset", {31'd0, err_sticky}, 32'd0);
        chk("R11 err after reset", {31'd0, bus_err}, 32'd0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rom();
        t_ram();
        t_fb();
        t_con();
        t_unmapped();
        t_rights();
        t_pulse();
        t_rereset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule